// File: doc/BRIEF.md
# Two-Level FFT Address Sequencer

This block drives a small local-memory FFT engine so that it can carry out a transform much larger than its own working memory. A transform of N = n1·n2 points is split into two levels. First come n2 sub-transforms of n1 points, each loaded from and stored back to external memory at a stride of n2. Then a rotation pass multiplies every intermediate sample by a twiddle factor. Last come n1 sub-transforms of n2 points over contiguous blocks. The external memory holds complex samples of 32 bits (16-bit real, 16-bit imaginary). The engine size n1 is fixed at 2^ENGINE_LOG2. Transforms no larger than the engine run as one level with no rotation pass.

The sequencer emits one beat per cycle on a valid/ready stream. Each beat carries an external sample address, a write flag, a phase code, the twiddle exponent and burst framing around every sub-transform load and store. A second mode walks a block as columns, visiting sample c + r·C for column c and row r, so that each column (one code period) arrives as one burst. The arithmetic and the twiddle table are outside this block.

Top module: `fft2l_seq`

## Requirements
- R1: After reset, o_vld, o_busy and o_done are 0 and o_phase is 0 (idle).
- R2: On i_start while idle, the effective log2 size L is i_log2n clamped to [MIN_LOG2, MAX_LOG2], and it is latched. If L <= ENGINE_LOG2, the run is one load burst over addresses 0..N-1 followed by one store burst over the same addresses, 2N beats in all, with no rotation beats.
- R3: If L > ENGINE_LOG2, let n1 = 2^ENGINE_LOG2 and n2 = N/n1. For k = 0..n2-1 in turn, the sequencer issues n1 load beats (phase code 1) at addresses k + j·n2, for j ascending from 0. These are followed by n1 store beats (phase code 2) at the same addresses. o_wr is 1 only on store beats (codes 2 and 5).
- R4: After level one, N rotation beats (phase code 3) visit addresses p = 0..N-1 in ascending order, with o_twiddle = (p div n2)·(p mod n2). o_twiddle is 0 on every beat that is not a rotation beat.
- R5: Level two then runs, for m = 0..n1-1 in turn, n2 load beats (phase code 4) at addresses m·n2 + i for i ascending, followed by n2 store beats (phase code 5) at the same addresses. A two-level run is 5N beats.
- R6: o_first is 1 exactly on the first beat of each load or store burst, and o_last is 1 exactly on its final beat. Both are 0 on rotation beats.
- R7: If i_col_mode is 1 at start, the run is N read beats (phase code 6, o_wr 0). C = 2^lc columns are visited, where lc is i_log2c clamped to at most L. Within column c (taken in ascending order), row r ascends over 0..N/C-1 at address c + r·C, and each column forms one burst.
- R8: A beat is taken when o_vld and i_rdy are both 1. While o_vld is 1 and i_rdy is 0, every beat output holds its value.
- R9: In the cycle after the final beat is taken, o_done is 1 for one cycle with o_vld 0. In the cycle after that, o_busy and o_done are 0.
- R10: i_start and new size or mode inputs while busy have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | Begin a run (sampled while idle) |
| i_log2n | input | LW | Requested log2 transform size |
| i_log2c | input | LW | log2 column count for column mode |
| i_col_mode | input | 1 | 1 selects the column walk instead of a transform |
| i_rdy | input | 1 | Downstream engine can take a beat |
| o_vld | output | 1 | Beat outputs are valid |
| o_phase | output | 3 | 1 L1 load, 2 L1 store, 3 rotate, 4 L2 load, 5 L2 store, 6 column, 0 otherwise |
| o_addr | output | MAX_LOG2 | External sample address |
| o_wr | output | 1 | Beat is a store |
| o_twiddle | output | MAX_LOG2 | Twiddle exponent (rotation beats) |
| o_first | output | 1 | First beat of a burst |
| o_last | output | 1 | Last beat of a burst |
| o_busy | output | 1 | Run in progress |
| o_done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the sequencer with MAX_LOG2 = 12, MIN_LOG2 = 3 and ENGINE_LOG2 = 5. The engine is then 32 points and the largest transform is 4096 points, a two-level run of 128 × 32 with 20480 beats. This keeps the largest run short while reaching all of the following: single-level runs, the two-level boundary at 64 points where n2 = 2, and both size clamps. Column walks with one-row columns bring bursts where first and last coincide. A random ready signal and stray start pulses exercise stalls and the rejection of starts during a run.

// File: rtl/fft2l_pkg.sv
package fft2l_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_L1_LD = 3'd1,
        PH_L1_ST = 3'd2,
        PH_ROT   = 3'd3,
        PH_L2_LD = 3'd4,
        PH_L2_ST = 3'd5,
        PH_COL   = 3'd6,
        PH_DONE  = 3'd7
    } phase_e;
endpackage

// File: rtl/fft2l_plan.sv
module fft2l_plan #(
    parameter int MAX_LOG2    = 18,
    parameter int MIN_LOG2    = 6,
    parameter int ENGINE_LOG2 = 9,
    parameter int LW          = $clog2(MAX_LOG2 + 1)
) (
    input  logic [LW-1:0] i_log2n,
    input  logic [LW-1:0] i_log2c,
    output logic [LW-1:0] o_ln,
    output logic [LW-1:0] o_l1,
    output logic [LW-1:0] o_l2,
    output logic [LW-1:0] o_lc
);
    localparam logic [LW-1:0] MINL = LW'(MIN_LOG2);
    localparam logic [LW-1:0] MAXL = LW'(MAX_LOG2);
    localparam logic [LW-1:0] ENGL = LW'(ENGINE_LOG2);

    always_comb begin
        if (i_log2n < MINL)      o_ln = MINL;
        else if (i_log2n > MAXL) o_ln = MAXL;
        else                     o_ln = i_log2n;
        o_l1 = (o_ln > ENGL) ? ENGL : o_ln;
        o_l2 = o_ln - o_l1;
        o_lc = (i_log2c > o_ln) ? o_ln : i_log2c;
    end
endmodule

// File: rtl/fft2l_addr_gen.sv
module fft2l_addr_gen
    import fft2l_pkg::*;
#(
    parameter int AW = 18,
    parameter int LW = 5
) (
    input  phase_e        i_ph,
    input  logic [AW-1:0] i_outer,
    input  logic [AW-1:0] i_inner,
    input  logic [LW-1:0] i_l2,
    input  logic [LW-1:0] i_lc,
    output logic [AW-1:0] o_addr,
    output logic [AW-1:0] o_tw
);
    always_comb begin
        o_addr = '0;
        o_tw   = '0;
        case (i_ph)
            PH_L1_LD, PH_L1_ST: o_addr = i_outer + (i_inner << i_l2);
            PH_ROT: begin
                o_addr = i_inner + (i_outer << i_l2);
                o_tw   = i_outer * i_inner;
            end
            PH_L2_LD, PH_L2_ST: o_addr = (i_outer << i_l2) + i_inner;
            PH_COL:             o_addr = i_outer + (i_inner << i_lc);
            default: ;
        endcase
    end
endmodule

// File: rtl/fft2l_seq.sv
module fft2l_seq
    import fft2l_pkg::*;
#(
    parameter int MAX_LOG2    = 18,
    parameter int MIN_LOG2    = 6,
    parameter int ENGINE_LOG2 = 9,
    parameter int LW          = $clog2(MAX_LOG2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i_start,
    input  logic [LW-1:0]       i_log2n,
    input  logic [LW-1:0]       i_log2c,
    input  logic                i_col_mode,
    input  logic                i_rdy,
    output logic                o_vld,
    output logic [2:0]          o_phase,
    output logic [MAX_LOG2-1:0] o_addr,
    output logic                o_wr,
    output logic [MAX_LOG2-1:0] o_twiddle,
    output logic                o_first,
    output logic                o_last,
    output logic                o_busy,
    output logic                o_done
);
    localparam int AW = MAX_LOG2;

    typedef struct packed {
        phase_e        ph;
        logic [AW-1:0] outer;
        logic [AW-1:0] inner;
        logic [LW-1:0] ln;
        logic [LW-1:0] l1;
        logic [LW-1:0] l2;
        logic [LW-1:0] lc;
    } seq_t;

    seq_t q, d;

    logic [LW-1:0] p_ln, p_l1, p_l2, p_lc;
    logic [AW-1:0] ilim, olim;
    logic          i_end, o_end, active, take;

    fft2l_plan #(
        .MAX_LOG2(MAX_LOG2), .MIN_LOG2(MIN_LOG2),
        .ENGINE_LOG2(ENGINE_LOG2), .LW(LW)
    ) u_plan (
        .i_log2n(i_log2n), .i_log2c(i_log2c),
        .o_ln(p_ln), .o_l1(p_l1), .o_l2(p_l2), .o_lc(p_lc)
    );

    fft2l_addr_gen #(.AW(AW), .LW(LW)) u_agen (
        .i_ph(q.ph), .i_outer(q.outer), .i_inner(q.inner),
        .i_l2(q.l2), .i_lc(q.lc),
        .o_addr(o_addr), .o_tw(o_twiddle)
    );

    function automatic logic [AW-1:0] mask_of(input logic [LW-1:0] sh);
        return (AW'(1) << sh) - AW'(1);
    endfunction

    always_comb begin
        ilim = '0;
        olim = '0;
        case (q.ph)
            PH_L1_LD, PH_L1_ST: begin ilim = mask_of(q.l1); olim = mask_of(q.l2); end
            PH_ROT, PH_L2_LD, PH_L2_ST: begin ilim = mask_of(q.l2); olim = mask_of(q.l1); end
            PH_COL: begin ilim = mask_of(q.ln - q.lc); olim = mask_of(q.lc); end
            default: ;
        endcase
        i_end  = (q.inner == ilim);
        o_end  = (q.outer == olim);
        active = (q.ph != PH_IDLE) && (q.ph != PH_DONE);
        take   = active && i_rdy;
    end

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: if (i_start) begin
                d.ln    = p_ln;
                d.l1    = p_l1;
                d.l2    = p_l2;
                d.lc    = p_lc;
                d.outer = '0;
                d.inner = '0;
                d.ph    = i_col_mode ? PH_COL : PH_L1_LD;
            end
            PH_DONE: d.ph = PH_IDLE;
            default: if (take) begin
                if (!i_end) begin
                    d.inner = q.inner + AW'(1);
                end else begin
                    d.inner = '0;
                    case (q.ph)
                        PH_L1_LD: d.ph = PH_L1_ST;
                        PH_L2_LD: d.ph = PH_L2_ST;
                        PH_L1_ST: begin
                            if (o_end) begin
                                d.outer = '0;
                                d.ph    = (q.l2 != '0) ? PH_ROT : PH_DONE;
                            end else begin
                                d.outer = q.outer + AW'(1);
                                d.ph    = PH_L1_LD;
                            end
                        end
                        PH_ROT: begin
                            if (o_end) begin
                                d.outer = '0;
                                d.ph    = PH_L2_LD;
                            end else begin
                                d.outer = q.outer + AW'(1);
                            end
                        end
                        PH_L2_ST: begin
                            if (o_end) begin
                                d.outer = '0;
                                d.ph    = PH_DONE;
                            end else begin
                                d.outer = q.outer + AW'(1);
                                d.ph    = PH_L2_LD;
                            end
                        end
                        PH_COL: begin
                            if (o_end) begin
                                d.outer = '0;
                                d.ph    = PH_DONE;
                            end else begin
                                d.outer = q.outer + AW'(1);
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        o_vld   = active;
        o_phase = active ? q.ph : PH_IDLE;
        o_wr    = (q.ph == PH_L1_ST) || (q.ph == PH_L2_ST);
        o_first = active && (q.ph != PH_ROT) && (q.inner == '0);
        o_last  = active && (q.ph != PH_ROT) && i_end;
        o_busy  = (q.ph != PH_IDLE);
        o_done  = (q.ph == PH_DONE);
    end

    // R8: a stalled beat holds all of its fields
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !i_rdy) |=> (o_vld && $stable(o_addr) && $stable(o_phase) &&
                               $stable(o_twiddle) && $stable(o_first) &&
                               $stable(o_last) && $stable(o_wr)));

    // R9: the done pulse is followed by idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_done |=> (!o_busy && !o_done));

    // R4: twiddle exponent is zero outside the rotation pass
    assert_tw_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && (o_phase != 3'd3)) |-> (o_twiddle == '0));

    // R6: burst framing only on valid non-rotation beats
    assert_burst_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (o_first || o_last) |-> (o_vld && (o_phase != 3'd3)));

    // R2: addresses stay inside the latched transform size
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> ((o_addr >> q.ln) == '0));

    // R3: a finished level-one load is followed by the matching store burst
    assert_store_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && i_rdy && o_last && (o_phase == 3'd1)) |=>
        ((o_phase == 3'd2) && o_first && o_wr));

    // R10: a start during a run leaves the latched size unchanged
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && i_start) |=> $stable(q.ln));
endmodule

// File: tb/fft2l_seq_tb.sv
module fft2l_seq_tb;
    localparam int MAXL = 12;
    localparam int MINL = 3;
    localparam int ENGL = 5;
    localparam int AW   = MAXL;
    localparam int LW   = $clog2(MAXL + 1);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          i_start = 0;
    logic [LW-1:0] i_log2n = '0;
    logic [LW-1:0] i_log2c = '0;
    logic          i_col_mode = 0;
    logic          i_rdy = 0;
    logic          o_vld, o_wr, o_first, o_last, o_busy, o_done;
    logic [2:0]    o_phase;
    logic [AW-1:0] o_addr, o_twiddle;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    fft2l_seq #(.MAX_LOG2(MAXL), .MIN_LOG2(MINL), .ENGINE_LOG2(ENGL), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_log2n(i_log2n),
        .i_log2c(i_log2c), .i_col_mode(i_col_mode), .i_rdy(i_rdy),
        .o_vld(o_vld), .o_phase(o_phase), .o_addr(o_addr), .o_wr(o_wr),
        .o_twiddle(o_twiddle), .o_first(o_first), .o_last(o_last),
        .o_busy(o_busy), .o_done(o_done)
    );

    typedef struct packed {
        logic [2:0]    ph;
        logic [AW-1:0] addr;
        logic [AW-1:0] tw;
        logic          wr;
        logic          first;
        logic          last;
    } beat_t;

    function automatic int clampl(int raw);
        if (raw < MINL) return MINL;
        if (raw > MAXL) return MAXL;
        return raw;
    endfunction

    function automatic beat_t exp_beat(int L, int lc, bit col, int idx);
        beat_t b;
        int n = 1 << L;
        int l1 = (L > ENGL) ? ENGL : L;
        int l2 = L - l1;
        int n1 = 1 << l1;
        int n2 = 1 << l2;
        b = '0;
        if (col) begin
            int nrow = n >> lc;
            int c = idx / nrow;
            int r = idx % nrow;
            b.ph = 3'd6; b.addr = AW'(c + r * (1 << lc));
            b.first = (r == 0); b.last = (r == nrow - 1);
        end else if (idx < 2 * n) begin
            int k = idx / (2 * n1);
            int r = idx % (2 * n1);
            int j = r % n1;
            b.wr = (r >= n1); b.ph = b.wr ? 3'd2 : 3'd1;
            b.addr = AW'(k + j * n2);
            b.first = (j == 0); b.last = (j == n1 - 1);
        end else if (idx < 3 * n) begin
            int p = idx - 2 * n;
            b.ph = 3'd3; b.addr = AW'(p);
            b.tw = AW'((p / n2) * (p % n2));
        end else begin
            int q = idx - 3 * n;
            int m = q / (2 * n2);
            int r = q % (2 * n2);
            int i = r % n2;
            b.wr = (r >= n2); b.ph = b.wr ? 3'd5 : 3'd4;
            b.addr = AW'(m * n2 + i);
            b.first = (i == 0); b.last = (i == n2 - 1);
        end
        return b;
    endfunction

    function automatic string tag_of(logic [2:0] ph, int L);
        if (L <= ENGL && ph != 3'd6) return "R2";
        case (ph)
            3'd1, 3'd2: return "R3";
            3'd3:       return "R4";
            3'd4, 3'd5: return "R5";
            default:    return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] got, logic [63:0] expv, string what);
        n_chk++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    task automatic run(int raw_l, int raw_c, bit col, int rdy_pct, bit poke);
        int L = clampl(raw_l);
        int lc = (raw_c > L) ? L : raw_c;
        int n = 1 << L;
        int total = col ? n : ((L > ENGL) ? 5 * n : 2 * n);
        int b = 0;
        bit stalled = 0;
        @(negedge clk);
        i_log2n = LW'(raw_l); i_log2c = LW'(raw_c); i_col_mode = col; i_start = 1;
        @(negedge clk);
        i_start = 0;
        while (b < total) begin
            beat_t e = exp_beat(L, lc, col, b);
            beat_t g;
            string t;
            g.ph = o_phase; g.addr = o_addr; g.tw = o_twiddle;
            g.wr = o_wr; g.first = o_first; g.last = o_last;
            if (poke) t = "R10"; else if (stalled) t = "R8"; else t = tag_of(e.ph, L);
            n_chk++;
            if (!o_vld || g[2*AW+5:3] !== e[2*AW+5:3]) begin
                n_bad++;
                $display("FAIL %s beat %0d: got vld=%0b ph=%0d addr=%0h tw=%0h wr=%0b expected ph=%0d addr=%0h tw=%0h wr=%0b",
                         t, b, o_vld, g.ph, g.addr, g.tw, g.wr, e.ph, e.addr, e.tw, e.wr);
            end
            chk("R6", {62'd0, g.first, g.last}, {62'd0, e.first, e.last}, "first/last");
            i_rdy = (($urandom % 100) < rdy_pct);
            if (poke) begin
                i_start = (($urandom % 16) == 0);
                i_log2n = LW'($urandom % 16);
                i_col_mode = ~col;
            end
            stalled = !i_rdy;
            if (i_rdy) b++;
            @(negedge clk);
        end
        i_start = 0; i_col_mode = 0;
        chk("R9", {62'd0, o_done, o_vld}, 64'd2, "done/vld after last");
        @(negedge clk);
        chk("R9", {62'd0, o_done, o_busy}, 64'd0, "done/busy idle");
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {58'd0, o_vld, o_busy, o_done, o_phase}, 64'd0, "reset outputs");
        run(3, 0, 0, 100, 0);   // R2 smallest single level
        run(1, 0, 0, 100, 0);   // R2 clamp up to MIN
        run(5, 0, 0, 60, 0);    // R2 engine-size boundary, stalls R8
        run(6, 0, 0, 100, 0);   // R3 R4 R5 with n2 = 2
        run(12, 0, 0, 75, 1);   // R10 starts during a run, random ready
        run(15, 0, 0, 100, 0);  // R2 clamp down to MAX, R3 R4 R5
        run(10, 3, 1, 70, 0);   // R7 eight columns
        run(8, 0, 1, 100, 0);   // R7 single column
        run(4, 7, 1, 50, 0);    // R7 column count clamped, one-row bursts
        for (int k = 0; k < 4; k++)
            run(int'($urandom % 11) + 3, int'($urandom % 8), 1'($urandom % 2), 80, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end
endmodule